// File: doc/BRIEF.md
# TDMA Burst Deframer

This block takes a stream of 2-bit symbols, one per cycle when `sym_valid` is high, and cuts it into 144-symbol bursts. Counting starts at reset. Each burst is split into its parts: a 24-bit access-channel field, three 72-bit voice payloads, and a 48-bit centre field that holds either a sync word or embedded signalling. The second voice payload is split into two halves, one on each side of the centre field.

The access-channel bits are put back into order through a fixed permutation. Their first seven bits form a Hamming(7,4) slot-type codeword. The block checks this codeword and, in correcting mode, repairs a single bad bit, then reads the slot number from it. The block compares the sign bits of the centre symbols against two sync patterns set by parameters. It also gathers the 16-bit embedded-signalling word and splits out its fields.

All results are registered together. A one-cycle `burst_done` pulse marks each completed burst, and the outputs stay unchanged until the next one.

Top module: `tdma_burst_deframer`

## Requirements
- R1: Burst symbols 0–11 form the access channel, 12–47 voice payload 1, 48–65 and 90–107 voice payload 2 (joined in that order), 66–89 the centre field, 108–143 voice payload 3. In `voice1`, `voice2` and `voice3`, bit index i is the i-th payload bit in arrival order.
- R2: Each symbol is unpacked high bit first, then low bit. `centre_bits[2k]` is the high bit of centre symbol k, and `centre_bits[2k+1]` is its low bit.
- R3: The access-channel bit arriving at position n (0..23) is stored at `cach_bits[T[n]]`, where T = 0,7,8,9,1,10,11,12,2,13,14,15,3,16,4,17,18,19,5,20,21,22,6,23.
- R4: The slot-type codeword is c = `cach_bits[6:0]`, with data bits c0..c3 and checks c4=c0^c1^c2, c5=c1^c2^c3, c6=c0^c1^c3. With `SLOT_FIX`=1, a word that fails the check has the single bit flipped that makes it pass. `slot_type` shows the corrected word, and `slot_num` is its bit 1.
- R5: With `SLOT_FIX`=0, any failed check marks the burst bad. A bad burst raises `burst_bad`, clears both sync flags, and leaves every other output at its previous value. With `SLOT_FIX`=1, `burst_bad` stays low.
- R6: `emb_word[i]` = `centre_bits[i]` for i<8, and `emb_word[8+i]` = `centre_bits[40+i]`. `color_code` = {emb 0,1,2,3} with bit 0 as the MSB. `pi_flag` = emb bit 4. `lc_ss` = {emb 5, emb 6}.
- R7: `voice_sync_hit` (or `data_sync_hit`) is high only when all 24 centre-symbol high bits equal `VOICE_SIGNS` (or `DATA_SIGNS`). Bit 23 of the pattern belongs to centre symbol 0. Low bits are ignored.
- R8: When `invert` is high, the high bit of each symbol is flipped before any other processing.
- R9: `burst_done` is high for exactly the one cycle after the clock edge that takes the 144th symbol. Between pulses, all outputs hold.
- R10: After reset, every output is zero.
- R11: Cycles with `sym_valid` low neither advance the burst position nor change any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | Symbol strobe |
| sym | input | 2 | Incoming symbol, high bit = sign |
| invert | input | 1 | Flip every symbol's high bit |
| burst_done | output | 1 | One-cycle completion pulse |
| burst_bad | output | 1 | Slot-type check failed (detect mode) |
| slot_num | output | 1 | Recovered slot number |
| slot_type | output | 7 | Corrected slot-type codeword |
| voice_sync_hit | output | 1 | Centre signs equal voice pattern |
| data_sync_hit | output | 1 | Centre signs equal data pattern |
| cach_bits | output | 24 | Deinterleaved access-channel bits |
| voice1 | output | 72 | Voice payload 1 |
| voice2 | output | 72 | Voice payload 2, both halves joined |
| voice3 | output | 72 | Voice payload 3 |
| centre_bits | output | 48 | Centre field bits |
| emb_word | output | 16 | Embedded-signalling word |
| color_code | output | 4 | Color code field |
| pi_flag | output | 1 | Pre-emption/power indicator |
| lc_ss | output | 2 | Link-control start/stop code |

## Verification
The bench builds two copies of the block side by side on the same symbol stream. One copy has `SLOT_FIX`=1 and the other `SLOT_FIX`=0. Both use the default sync patterns, which are bitwise complements of each other. Feeding the same stream to both means a single bad bit in the slot-type word is checked in one pass two ways: it must be repaired in one copy, and in the other it must be flagged with the earlier outputs kept. Two-bit errors show the repairing copy picking the wrong codeword. The centre fields include near-miss patterns with one wrong sign bit. Bursts arrive with the input inverted and with random idle gaps.

// File: rtl/tdma_deframer_pkg.sv
package tdma_deframer_pkg;

    localparam int CACH_SYMS   = 12;
    localparam int VF_SYMS     = 36;
    localparam int HALF_SYMS   = VF_SYMS / 2;
    localparam int CENTRE_SYMS = 24;
    localparam int BURST_SYMS  = CACH_SYMS + 2 * VF_SYMS + 2 * HALF_SYMS + CENTRE_SYMS;

    localparam int CACH_BITS   = 2 * CACH_SYMS;
    localparam int VF_BITS     = 2 * VF_SYMS;
    localparam int HALF_BITS   = 2 * HALF_SYMS;
    localparam int CENTRE_BITS = 2 * CENTRE_SYMS;
    localparam int BURST_BITS  = 2 * BURST_SYMS;

    localparam int VF1_OFS     = CACH_BITS;
    localparam int VF2A_OFS    = VF1_OFS + VF_BITS;
    localparam int CENTRE_OFS  = VF2A_OFS + HALF_BITS;
    localparam int VF2B_OFS    = CENTRE_OFS + CENTRE_BITS;
    localparam int VF3_OFS     = VF2B_OFS + HALF_BITS;

    localparam int ST_BITS     = 7;
    localparam int EMB_HEAD    = 8;
    localparam int EMB_BITS    = 2 * EMB_HEAD;
    localparam int EMB_TAIL    = CENTRE_BITS - EMB_HEAD;

    typedef logic [1:0] dibit_t;

    typedef struct packed {
        logic [CACH_BITS-1:0]   cach;
        logic [VF_BITS-1:0]     v1;
        logic [VF_BITS-1:0]     v2;
        logic [VF_BITS-1:0]     v3;
        logic [CENTRE_BITS-1:0] centre;
    } burst_fields_t;

    // destination of the access-channel bit arriving at position n
    function automatic int cach_slot(input int n);
        case (n)
            0: return 0;    1: return 7;    2: return 8;    3: return 9;
            4: return 1;    5: return 10;   6: return 11;   7: return 12;
            8: return 2;    9: return 13;  10: return 14;  11: return 15;
           12: return 3;   13: return 16;  14: return 4;   15: return 17;
           16: return 18;  17: return 19;  18: return 5;   19: return 20;
           20: return 21;  21: return 22;  22: return 6;   default: return 23;
        endcase
    endfunction

    function automatic logic [2:0] ham_parity(input logic [3:0] d);
        logic [2:0] p;
        p[0] = d[0] ^ d[1] ^ d[2];
        p[1] = d[1] ^ d[2] ^ d[3];
        p[2] = d[0] ^ d[1] ^ d[3];
        return p;
    endfunction

    // s[n] is the n-th bit of the burst in arrival order
    function automatic burst_fields_t split_stream(input logic [BURST_BITS-1:0] s);
        burst_fields_t f;
        f = '0;
        for (int n = 0; n < CACH_BITS; n++)   f.cach[cach_slot(n)] = s[n];
        for (int i = 0; i < VF_BITS; i++)     f.v1[i] = s[VF1_OFS + i];
        for (int i = 0; i < HALF_BITS; i++) begin
            f.v2[i]             = s[VF2A_OFS + i];
            f.v2[HALF_BITS + i] = s[VF2B_OFS + i];
        end
        for (int i = 0; i < CENTRE_BITS; i++) f.centre[i] = s[CENTRE_OFS + i];
        for (int i = 0; i < VF_BITS; i++)     f.v3[i] = s[VF3_OFS + i];
        return f;
    endfunction

endpackage

// File: rtl/tdma_symbol_sequencer.sv
module tdma_symbol_sequencer #(
    parameter int NSYM = 144
) (
    input  logic clk,
    input  logic rst,
    input  logic sym_valid,
    output logic last_sym
);
    localparam int CW = $clog2(NSYM);

    logic [CW-1:0] cnt;

    assign last_sym = sym_valid && (cnt == CW'(NSYM - 1));

    always_ff @(posedge clk) begin
        if (rst)           cnt <= '0;
        else if (last_sym) cnt <= '0;
        else if (sym_valid) cnt <= cnt + 1'b1;
    end

    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < CW'(NSYM));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |=> $stable(cnt));

endmodule

// File: rtl/tdma_slot_type_decoder.sv
module tdma_slot_type_decoder
    import tdma_deframer_pkg::*;
#(
    parameter bit SLOT_FIX = 1'b1
) (
    input  logic [ST_BITS-1:0] cw_in,
    output logic [ST_BITS-1:0] cw_out,
    output logic               cw_bad
);
    logic [2:0] syn;
    logic [ST_BITS-1:0] flip;

    assign syn = ham_parity(cw_in[3:0]) ^ cw_in[6:4];

    always_comb begin
        case (syn)
            3'b101:  flip = 7'b0000001;
            3'b111:  flip = 7'b0000010;
            3'b011:  flip = 7'b0000100;
            3'b110:  flip = 7'b0001000;
            3'b001:  flip = 7'b0010000;
            3'b010:  flip = 7'b0100000;
            3'b100:  flip = 7'b1000000;
            default: flip = 7'b0000000;
        endcase
    end

    generate
        if (SLOT_FIX) begin : g_fix
            assign cw_out = cw_in ^ flip;
            assign cw_bad = 1'b0;
        end else begin : g_detect
            assign cw_out = cw_in;
            assign cw_bad = (syn != 3'b000);
        end
    endgenerate

endmodule

// File: rtl/tdma_sync_matcher.sv
module tdma_sync_matcher
    import tdma_deframer_pkg::*;
#(
    parameter logic [CENTRE_SYMS-1:0] VOICE_SIGNS = 24'h439B4D,
    parameter logic [CENTRE_SYMS-1:0] DATA_SIGNS  = 24'hBC64B2
) (
    input  logic [CENTRE_BITS-1:0] centre,
    output logic                   voice_hit,
    output logic                   data_hit
);
    logic [CENTRE_SYMS-1:0] signs;

    generate
        for (genvar k = 0; k < CENTRE_SYMS; k++) begin : g_sign
            assign signs[CENTRE_SYMS-1-k] = centre[2*k];
        end
    endgenerate

    assign voice_hit = (signs == VOICE_SIGNS);
    assign data_hit  = (signs == DATA_SIGNS);

endmodule

// File: rtl/tdma_burst_deframer.sv
module tdma_burst_deframer
    import tdma_deframer_pkg::*;
#(
    parameter bit                     SLOT_FIX    = 1'b1,
    parameter logic [CENTRE_SYMS-1:0] VOICE_SIGNS = 24'h439B4D,
    parameter logic [CENTRE_SYMS-1:0] DATA_SIGNS  = 24'hBC64B2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sym_valid,
    input  logic [1:0]             sym,
    input  logic                   invert,
    output logic                   burst_done,
    output logic                   burst_bad,
    output logic                   slot_num,
    output logic [ST_BITS-1:0]     slot_type,
    output logic                   voice_sync_hit,
    output logic                   data_sync_hit,
    output logic [CACH_BITS-1:0]   cach_bits,
    output logic [VF_BITS-1:0]     voice1,
    output logic [VF_BITS-1:0]     voice2,
    output logic [VF_BITS-1:0]     voice3,
    output logic [CENTRE_BITS-1:0] centre_bits,
    output logic [EMB_BITS-1:0]    emb_word,
    output logic [3:0]             color_code,
    output logic                   pi_flag,
    output logic [1:0]             lc_ss
);
    localparam int HIST_BITS = BURST_BITS - 2;

    dibit_t                 d_in;
    logic [HIST_BITS-1:0]   hist;
    logic [BURST_BITS-1:0]  full;
    logic [BURST_BITS-1:0]  stream;
    burst_fields_t          fld;
    logic                   last_sym;
    logic [ST_BITS-1:0]     st_fixed;
    logic                   st_bad;
    logic                   v_hit, d_hit;
    logic [EMB_BITS-1:0]    emb_c;

    assign d_in = {sym[1] ^ invert, sym[0]};

    tdma_symbol_sequencer #(.NSYM(BURST_SYMS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .sym_valid (sym_valid),
        .last_sym  (last_sym)
    );

    always_ff @(posedge clk) begin
        if (rst)            hist <= '0;
        else if (sym_valid) hist <= {hist[HIST_BITS-3:0], d_in};
    end

    assign full = {hist, d_in};

    always_comb begin
        for (int n = 0; n < BURST_BITS; n++) stream[n] = full[BURST_BITS-1-n];
    end

    assign fld = split_stream(stream);

    tdma_slot_type_decoder #(.SLOT_FIX(SLOT_FIX)) u_st (
        .cw_in  (fld.cach[ST_BITS-1:0]),
        .cw_out (st_fixed),
        .cw_bad (st_bad)
    );

    tdma_sync_matcher #(.VOICE_SIGNS(VOICE_SIGNS), .DATA_SIGNS(DATA_SIGNS)) u_sync (
        .centre    (fld.centre),
        .voice_hit (v_hit),
        .data_hit  (d_hit)
    );

    assign emb_c = {fld.centre[CENTRE_BITS-1:EMB_TAIL], fld.centre[EMB_HEAD-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            burst_done     <= 1'b0;
            burst_bad      <= 1'b0;
            slot_num       <= 1'b0;
            slot_type      <= '0;
            voice_sync_hit <= 1'b0;
            data_sync_hit  <= 1'b0;
            cach_bits      <= '0;
            voice1         <= '0;
            voice2         <= '0;
            voice3         <= '0;
            centre_bits    <= '0;
            emb_word       <= '0;
            color_code     <= '0;
            pi_flag        <= 1'b0;
            lc_ss          <= '0;
        end else begin
            burst_done <= last_sym;
            if (last_sym) begin
                burst_bad      <= st_bad;
                voice_sync_hit <= v_hit && !st_bad;
                data_sync_hit  <= d_hit && !st_bad;
                if (!st_bad) begin
                    slot_num    <= st_fixed[1];
                    slot_type   <= st_fixed;
                    cach_bits   <= {fld.cach[CACH_BITS-1:ST_BITS], st_fixed};
                    voice1      <= fld.v1;
                    voice2      <= fld.v2;
                    voice3      <= fld.v3;
                    centre_bits <= fld.centre;
                    emb_word    <= emb_c;
                    color_code  <= {emb_c[0], emb_c[1], emb_c[2], emb_c[3]};
                    pi_flag     <= emb_c[4];
                    lc_ss       <= {emb_c[5], emb_c[6]};
                end
            end
        end
    end

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        burst_done |=> !burst_done);

    // R9
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !last_sym |=> ($stable(slot_type) && $stable(voice1) && $stable(voice2)
                       && $stable(voice3) && $stable(centre_bits) && !burst_done));

    // R5
    bad_no_sync_chk: assert property (@(posedge clk) disable iff (rst)
        burst_bad |-> (!voice_sync_hit && !data_sync_hit));

    // R4
    slot_code_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (burst_done && !burst_bad) |-> (ham_parity(slot_type[3:0]) == slot_type[6:4]));

    // R7
    sync_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        (VOICE_SIGNS != DATA_SIGNS) |-> !(voice_sync_hit && data_sync_hit));

endmodule

// File: tb/tdma_burst_deframer_bench.sv
module tdma_burst_deframer_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [23:0] VS = 24'h439B4D;
    localparam logic [23:0] DS = 24'hBC64B2;

    typedef struct packed {
        logic        slot;
        logic [6:0]  st;
        logic [23:0] cach;
        logic [71:0] v1, v2, v3;
        logic [47:0] ctr;
        logic [15:0] emb;
        logic [3:0]  cc;
        logic        pi;
        logic [1:0]  ls;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sym_valid = 1'b0;
    logic [1:0] sym = 2'b00;
    logic invert = 1'b0;

    logic [1:0]        done_o, bad_o, slot_o, vh_o, dh_o, pi_o;
    logic [1:0][6:0]   st_o;
    logic [1:0][23:0]  cach_o;
    logic [1:0][71:0]  v1_o, v2_o, v3_o;
    logic [1:0][47:0]  ctr_o;
    logic [1:0][15:0]  emb_o;
    logic [1:0][3:0]   cc_o;
    logic [1:0][1:0]   ls_o;

    int total = 0;
    int fails = 0;
    logic [1:0] bs [144];
    exp_t hold [2];
    int tbl [24] = '{0,7,8,9,1,10,11,12,2,13,14,15,3,16,4,17,18,19,5,20,21,22,6,23};

    always #(CLK_PERIOD/2) clk = ~clk;

    tdma_burst_deframer #(.SLOT_FIX(1'b1), .VOICE_SIGNS(VS), .DATA_SIGNS(DS)) u_tdma_burst_deframer (
        .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym(sym), .invert(invert),
        .burst_done(done_o[0]), .burst_bad(bad_o[0]), .slot_num(slot_o[0]), .slot_type(st_o[0]),
        .voice_sync_hit(vh_o[0]), .data_sync_hit(dh_o[0]), .cach_bits(cach_o[0]),
        .voice1(v1_o[0]), .voice2(v2_o[0]), .voice3(v3_o[0]), .centre_bits(ctr_o[0]),
        .emb_word(emb_o[0]), .color_code(cc_o[0]), .pi_flag(pi_o[0]), .lc_ss(ls_o[0]));

    tdma_burst_deframer #(.SLOT_FIX(1'b0), .VOICE_SIGNS(VS), .DATA_SIGNS(DS)) u_tdma_burst_deframer_det (
        .clk(clk), .rst(rst), .sym_valid(sym_valid), .sym(sym), .invert(invert),
        .burst_done(done_o[1]), .burst_bad(bad_o[1]), .slot_num(slot_o[1]), .slot_type(st_o[1]),
        .voice_sync_hit(vh_o[1]), .data_sync_hit(dh_o[1]), .cach_bits(cach_o[1]),
        .voice1(v1_o[1]), .voice2(v2_o[1]), .voice3(v3_o[1]), .centre_bits(ctr_o[1]),
        .emb_word(emb_o[1]), .color_code(cc_o[1]), .pi_flag(pi_o[1]), .lc_ss(ls_o[1]));

    task automatic chk(input string req, input string what, input logic [71:0] act, input logic [71:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] par3(input logic [3:0] d);
        return {d[0]^d[1]^d[3], d[1]^d[2]^d[3], d[0]^d[1]^d[2]};
    endfunction

    function automatic logic sbit(input int n);
        return (n % 2 == 0) ? bs[n/2][1] : bs[n/2][0];
    endfunction

    // build a burst: slot-type data, error mask on the codeword, centre kind
    task automatic make_burst(input logic [3:0] data, input logic [6:0] emask, input int kind);
        logic [6:0]  cw;
        logic [23:0] deint;
        logic [23:0] pat;
        for (int k = 0; k < 144; k++) bs[k] = 2'($urandom);
        cw = {par3(data), data} ^ emask;
        deint = {17'($urandom), cw};
        for (int n = 0; n < 24; n += 2) bs[n/2] = {deint[tbl[n]], deint[tbl[n+1]]};
        if (kind != 0) begin
            pat = (kind == 2) ? DS : VS;
            if (kind == 3) pat[$urandom % 24] ^= 1'b1;
            for (int s = 0; s < 24; s++) bs[66+s][1] = pat[23-s];
        end
    endtask

    task automatic send(input logic inv, input int gap);
        invert = inv;
        for (int k = 0; k < 144; k++) begin
            int idle = (gap > 0) ? int'($urandom % (gap + 1)) : 0;
            repeat (idle) begin
                @(negedge clk); sym_valid = 1'b0; sym = 2'($urandom);
            end
            @(negedge clk); sym_valid = 1'b1; sym = bs[k] ^ {inv, 1'b0};
        end
        @(negedge clk); sym_valid = 1'b0; sym = 2'($urandom);
    endtask

    task automatic verify();
        exp_t e;
        logic [6:0] cw, fixed;
        logic nz;
        logic [23:0] signs;
        logic vh, dh;
        for (int i = 0; i < 24; i++) e.cach[tbl[i]] = sbit(i);
        for (int i = 0; i < 72; i++) begin
            e.v1[i] = sbit(24 + i);
            e.v2[i] = (i < 36) ? sbit(96 + i) : sbit(144 + i);
            e.v3[i] = sbit(216 + i);
        end
        for (int i = 0; i < 48; i++) e.ctr[i] = sbit(132 + i);
        for (int i = 0; i < 8; i++) begin
            e.emb[i] = e.ctr[i];
            e.emb[8+i] = e.ctr[40+i];
        end
        e.cc = {e.emb[0], e.emb[1], e.emb[2], e.emb[3]};
        e.pi = e.emb[4];
        e.ls = {e.emb[5], e.emb[6]};
        cw = e.cach[6:0];
        nz = (par3(cw[3:0]) != cw[6:4]);
        fixed = cw;
        if (nz) begin
            for (int j = 0; j < 7; j++) begin
                logic [6:0] t = cw ^ (7'd1 << j);
                if (par3(t[3:0]) == t[6:4]) fixed = t;
            end
        end
        for (int s = 0; s < 24; s++) signs[23-s] = e.ctr[2*s];
        vh = (signs == VS);
        dh = (signs == DS);
        for (int u = 0; u < 2; u++) begin
            logic isbad = (u == 1) && nz;
            exp_t x;
            if (!isbad) begin
                x = e;
                x.st = (u == 0) ? fixed : cw;
                x.cach[6:0] = x.st;
                x.slot = x.st[1];
                hold[u] = x;
            end
            x = hold[u];
            chk("R9", $sformatf("done u%0d", u), 72'(done_o[u]), 72'd1);
            chk("R5", $sformatf("bad u%0d", u), 72'(bad_o[u]), 72'(isbad));
            chk("R4", $sformatf("slot u%0d", u), 72'(slot_o[u]), 72'(x.slot));
            chk("R4", $sformatf("slot_type u%0d", u), 72'(st_o[u]), 72'(x.st));
            chk("R3", $sformatf("cach u%0d", u), 72'(cach_o[u]), 72'(x.cach));
            chk("R1", $sformatf("voice1 u%0d", u), v1_o[u], x.v1);
            chk("R1", $sformatf("voice2 u%0d", u), v2_o[u], x.v2);
            chk("R1", $sformatf("voice3 u%0d", u), v3_o[u], x.v3);
            chk("R2", $sformatf("centre u%0d", u), 72'(ctr_o[u]), 72'(x.ctr));
            chk("R6", $sformatf("emb u%0d", u), 72'(emb_o[u]), 72'(x.emb));
            chk("R6", $sformatf("fields u%0d", u), 72'({cc_o[u], pi_o[u], ls_o[u]}),
                72'({x.cc, x.pi, x.ls}));
            chk("R7", $sformatf("voice hit u%0d", u), 72'(vh_o[u]), 72'(vh && !isbad));
            chk("R7", $sformatf("data hit u%0d", u), 72'(dh_o[u]), 72'(dh && !isbad));
        end
        @(negedge clk);
        for (int u = 0; u < 2; u++) begin
            chk("R9", $sformatf("pulse end u%0d", u), 72'(done_o[u]), 72'd0);
            chk("R9", $sformatf("hold u%0d", u), v3_o[u], hold[u].v3);
        end
    endtask

    task automatic run(input logic [3:0] data, input logic [6:0] emask, input int kind,
                       input logic inv, input int gap);
        make_burst(data, emask, kind);
        send(inv, gap);
        verify();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED0042));
        hold[0] = '0;
        hold[1] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int u = 0; u < 2; u++) begin
            chk("R10", $sformatf("reset outs u%0d", u),
                72'({done_o[u], bad_o[u], slot_o[u], st_o[u], vh_o[u], dh_o[u], cc_o[u], pi_o[u], ls_o[u]}), 72'd0);
            chk("R10", $sformatf("reset voice u%0d", u), v1_o[u] | v2_o[u] | v3_o[u], 72'd0);
        end
        // R11: idle symbols while valid low must not move the outputs
        repeat (20) begin
            @(negedge clk); sym = 2'($urandom);
        end
        chk("R11", "idle no done", 72'(done_o), 72'd0);
        run(4'b0101, 7'd0, 1, 1'b0, 0);          // clean, voice sync
        run(4'b0010, 7'd0, 2, 1'b1, 0);          // R8 inverted input, data sync
        run(4'b1011, 7'b0000010, 1, 1'b0, 0);    // single error on slot bit, R5 hold
        run(4'b0110, 7'b1000000, 2, 1'b0, 3);    // parity error, R11 gaps
        run(4'b1100, 7'b0011000, 0, 1'b0, 0);    // double error: miscorrect
        run(4'b0000, 7'd0, 3, 1'b0, 0);          // near-miss voice sync
        run(4'b1111, 7'd0, 3, 1'b1, 2);          // near-miss, inverted, gaps
        for (int r = 0; r < 40; r++) begin
            logic [6:0] em = ($urandom % 3 == 0) ? 7'(1 << ($urandom % 7)) : 7'd0;
            run(4'($urandom), em, int'($urandom % 4), 1'($urandom), int'($urandom % 3));
        end
        $display("  test done: total=%0d bad=%0d", total, fails);
        $finish;
    end

endmodule